// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside an on-chip flash array and watches the write cycles a microcontroller issues to it. Writes are not stored. They are decoded as multi-byte command sequences. Each sequence opens with two unlock writes and then a command byte. Some commands take further bytes. When a sequence completes, the block raises a single-cycle start pulse toward the program or erase engine, or toward the suspend and resume logic. The pulse carries the latched address, data, array and sector. Any malformed byte, a byte aimed at the wrong array, or too long a pause between bytes drops the decoder back to read-array mode.

Sector-select lines choose the target array. There are eight primary lines and four boot lines. The decoder also drives the read-data path. It returns array contents in normal mode and a status byte while the engine is busy. In identifier mode, a read at certain address bit patterns returns the configured identifier byte or a sector's protection flag. An unlock-bypass mode lets byte programs be issued without the unlock prefix.

The write strobe is asynchronous. It is synchronised and captured on its rising edge. A strobe that is already low when reset is released is ignored until it has been seen high once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read-array mode. rdata_o equals array_data_i, bypass_o and status_rd_o are 0, and no start pulse is issued.
- R2: A sequence opens with data AAh at an address whose bits 11:0 are 555h, followed by data 55h at an address whose bits 11:0 are AAAh. The command byte follows at bits 11:0 = 555h. Address bits 15:12 are ignored throughout.
- R3: A write is taken only if at least one select line is high. Any high psel_i bit picks the primary array (op_arr_o = 0), and primary wins when both groups are high. Otherwise any high bsel_i bit picks the secondary array (op_arr_o = 1). The sector index is the lowest high primary line (0 to 7), or 8 plus the lowest high boot line. A write with no select line high is ignored and leaves the sequence state untouched.
- R4: The array is latched at the first unlock write. A wrong data byte, a wrong address, or a write to the other array in the middle of a sequence returns the decoder to read-array mode without a pulse.
- R5: Once a sequence is partly received, a gap of TIMEOUT_CYC clock cycles or more between accepted writes aborts it to read-array mode. Shorter gaps do not abort it.
- R6: A write strobed while lockout_i is high is ignored and changes no state.
- R7: If wr_ni is low when reset is released, its first rising edge is not taken as a write.
- R8: Command A0h is followed by one write. That write issues a one-cycle prog_start_o with op_addr_o, op_data_o, op_arr_o and op_sector_o taken from it.
- R9: Command 80h, then a second unlock pair, then 10h at 555h issues chip_erase_o. In place of 10h, 30h at any address issues sector_erase_o with the sector of that write.
- R10: Command B0h issues suspend_o and command 30h issues resume_o. Both return to read-array mode. Command F0h and any unlisted command byte return to read-array mode with no pulse.
- R11: Command 90h enters identifier mode. Reads with {A6,A1,A0} = 001 on a primary select return ID_CODE when the mode was entered on the primary array. Reads with {A6,A1,A0} = 010 return 01h if prot_i of the selected sector is set and 00h if not. Other reads return array data. Any accepted write leaves identifier mode.
- R12: Command 20h enters bypass mode (bypass_o = 1). There, A0h followed by one write programs as in R8, and 90h followed by 00h exits to read-array mode. Any other byte, a timeout, or a 90h followed by a non-zero byte leaves the decoder in bypass mode.
- R13: While busy_i is high, rdata_o returns status_i and status_rd_o is 1.
- R14: The start pulses last one cycle each and are mutually exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Asynchronous write strobe, active low |
| addr_i | input | ADDR_W (16) | Bus address |
| data_i | input | 8 | Write data |
| psel_i | input | N_PRI (8) | Primary array sector selects |
| bsel_i | input | N_BOOT (4) | Secondary array sector selects |
| lockout_i | input | 1 | Supply lockout, blocks all writes |
| busy_i | input | 1 | Program/erase engine busy |
| status_i | input | 8 | Engine status byte |
| array_data_i | input | 8 | Array read data |
| prot_i | input | N_PRI+N_BOOT (12) | Per-sector protect flags |
| rdata_o | output | 8 | Read data toward the bus |
| status_rd_o | output | 1 | Read data is the status byte |
| prog_start_o | output | 1 | Byte program start pulse |
| chip_erase_o | output | 1 | Chip erase start pulse |
| sector_erase_o | output | 1 | Sector erase start pulse |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |
| op_addr_o | output | ADDR_W (16) | Latched operation address |
| op_data_o | output | 8 | Latched operation data |
| op_arr_o | output | 1 | Latched array, 1 = secondary |
| op_sector_o | output | SEC_W (4) | Latched sector index |
| bypass_o | output | 1 | Bypass mode active |

## Verification
The bench builds the decoder with TIMEOUT_CYC = 64 and ID_CODE = E7h and keeps the default widths of eight primary and four boot selects. The short timeout lets both sides of the gap rule be tested within a few hundred cycles: a 40-cycle gap keeps a sequence alive and an 80-cycle gap aborts it, both in normal mode and inside bypass. The full select set puts the priority, lowest-line sector numbering and secondary-array paths within reach. The non-default identifier checks that the parameter reaches the read path.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS, ST_EUNL1, ST_EUNL2,
    ST_IDMODE, ST_BYP, ST_BYP_PROG, ST_BYP_EXIT
  } fcd_state_e;

  localparam logic [7:0] UNL_D1     = 8'hAA;
  localparam logic [7:0] UNL_D2     = 8'h55;
  localparam logic [11:0] UNL_A1    = 12'h555;
  localparam logic [11:0] UNL_A2    = 12'hAAA;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_BYPEND = 8'h00;

  // states waiting for a further byte, subject to the gap timer
  function automatic logic is_partial(fcd_state_e s);
    return (s == ST_UNL1) || (s == ST_UNL2) || (s == ST_PROG) ||
           (s == ST_ERS) || (s == ST_EUNL1) || (s == ST_EUNL2) ||
           (s == ST_BYP_PROG) || (s == ST_BYP_EXIT);
  endfunction
endpackage

// File: rtl/fcd_wr_sync.sv
module fcd_wr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q, armed_q;

  // sync stages reset low: a strobe low at release is never mistaken for high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      s1_q    <= wr_ni;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      armed_q <= armed_q | s3_q;
    end
  end

  assign rise_o = s2_q & ~s3_q & armed_q;
endmodule

// File: rtl/fcd_sel.sv
module fcd_sel #(
  parameter int N_PRI  = 8,
  parameter int N_BOOT = 4,
  localparam int SEC_W = $clog2(N_PRI + N_BOOT)
) (
  input  logic [N_PRI-1:0]  psel_i,
  input  logic [N_BOOT-1:0] bsel_i,
  output logic              valid_o,
  output logic              arr_o,
  output logic [SEC_W-1:0]  sector_o
);
  logic [SEC_W-1:0] pidx, bidx;

  always_comb begin
    pidx = '0;
    for (int i = N_PRI - 1; i >= 0; i--)
      if (psel_i[i]) pidx = SEC_W'(i);
  end

  always_comb begin
    bidx = '0;
    for (int i = N_BOOT - 1; i >= 0; i--)
      if (bsel_i[i]) bidx = SEC_W'(N_PRI + i);
  end

  assign valid_o  = (|psel_i) | (|bsel_i);
  assign arr_o    = ~(|psel_i);
  assign sector_o = (|psel_i) ? pidx : bidx;
endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
  parameter int TIMEOUT_CYC = 1024,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic fire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= TW'(TIMEOUT_CYC);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = run_i && !load_i && (cnt_q == '0);
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              tmo_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              arr_i,
  input  logic [SEC_W-1:0]  sector_i,
  output fcd_state_e        state_o,
  output logic              mode_arr_o,
  output logic              prog_o,
  output logic              chip_o,
  output logic              sect_o,
  output logic              susp_o,
  output logic              res_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic              op_arr_o,
  output logic [SEC_W-1:0]  op_sector_o
);
  fcd_state_e state_q, nxt;
  logic mode_arr_q, mode_arr_d;
  logic p_prog, p_chip, p_sect, p_susp, p_res;
  logic a1, a2, arr_ok, any_p;

  assign a1     = addr_i[11:0] == UNL_A1;
  assign a2     = addr_i[11:0] == UNL_A2;
  assign arr_ok = arr_i == mode_arr_q;

  always_comb begin
    nxt        = state_q;
    mode_arr_d = mode_arr_q;
    p_prog = 1'b0; p_chip = 1'b0; p_sect = 1'b0; p_susp = 1'b0; p_res = 1'b0;
    if (evt_i) begin
      unique case (state_q)
        ST_READ: if (data_i == UNL_D1 && a1) begin
          nxt        = ST_UNL1;
          mode_arr_d = arr_i;
        end
        ST_UNL1: nxt = (arr_ok && a2 && data_i == UNL_D2) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          nxt = ST_READ;
          if (arr_ok && a1) begin
            unique case (data_i)
              CMD_IDENT:  nxt = ST_IDMODE;
              CMD_PROG:   nxt = ST_PROG;
              CMD_ERASE:  nxt = ST_ERS;
              CMD_BYPASS: nxt = ST_BYP;
              CMD_SUSP:   p_susp = 1'b1;
              CMD_RESUME: p_res  = 1'b1;
              default:    nxt = ST_READ;
            endcase
          end
        end
        ST_PROG: begin
          nxt    = ST_READ;
          p_prog = arr_ok;
        end
        ST_ERS:   nxt = (arr_ok && a1 && data_i == UNL_D1) ? ST_EUNL1 : ST_READ;
        ST_EUNL1: nxt = (arr_ok && a2 && data_i == UNL_D2) ? ST_EUNL2 : ST_READ;
        ST_EUNL2: begin
          nxt    = ST_READ;
          p_chip = arr_ok && a1 && data_i == CMD_CHIP;
          p_sect = arr_ok && data_i == CMD_SECT;
        end
        ST_IDMODE: nxt = ST_READ;
        ST_BYP: begin
          if (arr_ok && data_i == CMD_PROG)       nxt = ST_BYP_PROG;
          else if (arr_ok && data_i == CMD_IDENT) nxt = ST_BYP_EXIT;
        end
        ST_BYP_PROG: begin
          nxt    = ST_BYP;
          p_prog = arr_ok;
        end
        ST_BYP_EXIT: nxt = (arr_ok && data_i == CMD_BYPEND) ? ST_READ : ST_BYP;
        default: nxt = ST_READ;
      endcase
    end else if (tmo_i) begin
      nxt = (state_q == ST_BYP_PROG || state_q == ST_BYP_EXIT) ? ST_BYP : ST_READ;
    end
  end

  assign any_p = p_prog | p_chip | p_sect | p_susp | p_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_READ;
      mode_arr_q  <= 1'b0;
      prog_o      <= 1'b0;
      chip_o      <= 1'b0;
      sect_o      <= 1'b0;
      susp_o      <= 1'b0;
      res_o       <= 1'b0;
      op_addr_o   <= '0;
      op_data_o   <= '0;
      op_arr_o    <= 1'b0;
      op_sector_o <= '0;
    end else begin
      state_q    <= nxt;
      mode_arr_q <= mode_arr_d;
      prog_o     <= p_prog;
      chip_o     <= p_chip;
      sect_o     <= p_sect;
      susp_o     <= p_susp;
      res_o      <= p_res;
      if (any_p) begin
        op_addr_o   <= addr_i;
        op_data_o   <= data_i;
        op_arr_o    <= arr_i;
        op_sector_o <= sector_i;
      end
    end
  end

  assign state_o    = state_q;
  assign mode_arr_o = mode_arr_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         N_PRI       = 8,
  parameter int         N_BOOT      = 4,
  parameter int         TIMEOUT_CYC = 1024,
  parameter logic [7:0] ID_CODE     = 8'hE4,
  localparam int        N_SEC       = N_PRI + N_BOOT,
  localparam int        SEC_W       = $clog2(N_SEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [N_PRI-1:0]  psel_i,
  input  logic [N_BOOT-1:0] bsel_i,
  input  logic              lockout_i,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        array_data_i,
  input  logic [N_SEC-1:0]  prot_i,
  output logic [7:0]        rdata_o,
  output logic              status_rd_o,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic              op_arr_o,
  output logic [SEC_W-1:0]  op_sector_o,
  output logic              bypass_o
);
  logic             wr_rise, acc_evt, tmo;
  logic             sel_valid, sel_arr;
  logic [SEC_W-1:0] sel_sector;
  logic             mode_arr;
  fcd_state_e       state;
  logic [2:0]       spec_bits;

  fcd_wr_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_ni  (wr_ni),
    .rise_o (wr_rise)
  );

  fcd_sel #(.N_PRI(N_PRI), .N_BOOT(N_BOOT)) u_sel (
    .psel_i   (psel_i),
    .bsel_i   (bsel_i),
    .valid_o  (sel_valid),
    .arr_o    (sel_arr),
    .sector_o (sel_sector)
  );

  assign acc_evt = wr_rise & ~lockout_i & sel_valid;

  fcd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc_evt),
    .run_i  (is_partial(state)),
    .fire_o (tmo)
  );

  fcd_fsm #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (acc_evt),
    .tmo_i       (tmo),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .arr_i       (sel_arr),
    .sector_i    (sel_sector),
    .state_o     (state),
    .mode_arr_o  (mode_arr),
    .prog_o      (prog_start_o),
    .chip_o      (chip_erase_o),
    .sect_o      (sector_erase_o),
    .susp_o      (suspend_o),
    .res_o       (resume_o),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o),
    .op_arr_o    (op_arr_o),
    .op_sector_o (op_sector_o)
  );

  assign spec_bits = {addr_i[6], addr_i[1], addr_i[0]};

  always_comb begin
    rdata_o = array_data_i;
    if (busy_i) rdata_o = status_i;
    else if (state == ST_IDMODE && sel_valid) begin
      if (spec_bits == 3'b001 && !sel_arr && !mode_arr) rdata_o = ID_CODE;
      else if (spec_bits == 3'b010) rdata_o = {7'b0, prot_i[sel_sector]};
    end
  end

  assign status_rd_o = busy_i;
  assign bypass_o    = (state == ST_BYP) || (state == ST_BYP_PROG) || (state == ST_BYP_EXIT);
endmodule

// File: rtl/fcd_checks.sv
module fcd_checks
  import fcd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input fcd_state_e state_i,
  input logic       wr_rise_i,
  input logic       acc_evt_i,
  input logic       tmo_i,
  input logic       sel_valid_i,
  input logic       lockout_i,
  input logic [4:0] pulses_i
);
  assert_onehot_pulses_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulses_i));

  assert_pulse_single_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulses_i) |=> !(|pulses_i));

  assert_pulse_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulses_i) |-> $past(acc_evt_i));

  assert_lockout_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise_i && lockout_i && !tmo_i) |=> ($stable(state_i) && !(|pulses_i)));

  assert_unselected_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise_i && !sel_valid_i && !tmo_i) |=> $stable(state_i));

  assert_timeout_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> (state_i == ST_READ || state_i == ST_BYP));
endmodule

bind flash_cmd_decoder fcd_checks u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state),
  .wr_rise_i   (wr_rise),
  .acc_evt_i   (acc_evt),
  .tmo_i       (tmo),
  .sel_valid_i (sel_valid),
  .lockout_i   (lockout_i),
  .pulses_i    ({prog_start_o, chip_erase_o, sector_erase_o, suspend_o, resume_o})
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int TMO = 64;
  localparam logic [7:0] IDC = 8'hE7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  psel = '0;
  logic [3:0]  bsel = '0;
  logic        lockout = 1'b0;
  logic        busy = 1'b0;
  logic [7:0]  status = 8'hC3;
  logic [11:0] prot = 12'h804;
  logic [7:0]  arr_data;
  logic [7:0]  rdata;
  logic        status_rd, prog_s, chip_s, sect_s, susp_s, res_s, op_arr, bypass;
  logic [15:0] op_addr;
  logic [7:0]  op_data;
  logic [3:0]  op_sector;

  assign arr_data = addr[7:0] ^ 8'h5A;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.TIMEOUT_CYC(TMO), .ID_CODE(IDC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .addr_i(addr), .data_i(data),
    .psel_i(psel), .bsel_i(bsel), .lockout_i(lockout), .busy_i(busy),
    .status_i(status), .array_data_i(arr_data), .prot_i(prot),
    .rdata_o(rdata), .status_rd_o(status_rd), .prog_start_o(prog_s),
    .chip_erase_o(chip_s), .sector_erase_o(sect_s), .suspend_o(susp_s),
    .resume_o(res_s), .op_addr_o(op_addr), .op_data_o(op_data),
    .op_arr_o(op_arr), .op_sector_o(op_sector), .bypass_o(bypass)
  );

  int n_chk = 0, n_fail = 0;
  logic [4:0]  mon_mask = '0;
  int          mon_cyc = 0;
  logic [15:0] mon_addr = '0;
  logic [7:0]  mon_data = '0;
  logic        mon_arr = 1'b0;
  logic [3:0]  mon_sec = '0;

  // mask bits: 0 program, 1 chip erase, 2 sector erase, 3 suspend, 4 resume
  always @(posedge clk) begin
    if (prog_s | chip_s | sect_s | susp_s | res_s) begin
      mon_mask <= mon_mask | {res_s, susp_s, sect_s, chip_s, prog_s};
      mon_cyc  <= mon_cyc + 1;
      mon_addr <= op_addr;
      mon_data <= op_data;
      mon_arr  <= op_arr;
      mon_sec  <= op_sector;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    mon_mask = '0;
    mon_cyc  = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input logic [7:0] p, input logic [3:0] b);
    @(negedge clk);
    addr = a; data = d; psel = p; bsel = b; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    psel = '0; bsel = '0;
  endtask

  task automatic unl(input logic [7:0] p, input logic [3:0] b);
    wr(16'h0555, 8'hAA, p, b);
    wr(16'h0AAA, 8'h55, p, b);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] p, input logic [3:0] b,
                    output logic [7:0] v);
    @(negedge clk);
    addr = a; psel = p; bsel = b;
    #1 v = rdata;
    psel = '0; bsel = '0;
  endtask

  typedef struct packed {
    logic [7:0] cmd;
    logic [4:0] mask;
    logic       byp;
    logic       id;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hF0, 5'b00000, 1'b0, 1'b0},
    '{8'hB0, 5'b01000, 1'b0, 1'b0},
    '{8'h30, 5'b10000, 1'b0, 1'b0},
    '{8'h90, 5'b00000, 1'b0, 1'b1},
    '{8'h20, 5'b00000, 1'b1, 1'b0},
    '{8'h77, 5'b00000, 1'b0, 1'b0}
  };

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    rd(16'h0010, 8'h01, 4'h0, v);
    chk("R1 array read", v, 8'h4A);
    chk("R1 bypass", bypass, 0);
    chk("R1 status flag", status_rd, 0);
    chk("R1 no pulse", mon_mask, 0);

    // R10 R11 R12 R2 command table
    foreach (VECS[i]) begin
      clr();
      unl(8'h01, 4'h0);
      wr(16'h0555, VECS[i].cmd, 8'h01, 4'h0);
      chk($sformatf("R10 pulses cmd %h", VECS[i].cmd), mon_mask, VECS[i].mask);
      chk($sformatf("R12 bypass cmd %h", VECS[i].cmd), bypass, VECS[i].byp);
      rd(16'h0001, 8'h01, 4'h0, v);
      chk($sformatf("R11 id cmd %h", VECS[i].cmd), v, VECS[i].id ? IDC : 8'h5B);
      if (VECS[i].byp) begin
        wr(16'h0000, 8'h90, 8'h01, 4'h0);
        wr(16'h0000, 8'h00, 8'h01, 4'h0);
      end
      if (VECS[i].id) wr(16'h0000, 8'hF0, 8'h01, 4'h0);
      chk("R12 back to read", bypass, 0);
    end

    // R2 upper address bits ignored
    wr(16'hF555, 8'hAA, 8'h01, 4'h0);
    wr(16'h3AAA, 8'h55, 8'h01, 4'h0);
    wr(16'h7555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v);
    chk("R2 high bits ignored", v, IDC);
    // R11 protection reads
    rd(16'h0002, 8'h04, 4'h0, v); chk("R11 prot sec2", v, 8'h01);
    rd(16'h0002, 8'h01, 4'h0, v); chk("R11 prot sec0", v, 8'h00);
    rd(16'h0002, 8'h00, 4'h8, v); chk("R11 prot sec11", v, 8'h01);
    rd(16'h0041, 8'h01, 4'h0, v); chk("R11 A6 set", v, 8'h1B);
    rd(16'h0001, 8'h00, 4'h1, v); chk("R11 id on secondary", v, 8'h5B);
    wr(16'h0555, 8'hF0, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R11 exit", v, 8'h5B);

    // R11 mode entered on secondary
    unl(8'h00, 4'h1);
    wr(16'h0555, 8'h90, 8'h00, 4'h1);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R11 no id secondary mode", v, 8'h5B);
    rd(16'h0002, 8'h00, 4'h8, v); chk("R11 prot secondary mode", v, 8'h01);
    wr(16'h0000, 8'hF0, 8'h00, 4'h1);

    // R8 program, R14 single cycle
    clr();
    unl(8'h02, 4'h0);
    wr(16'h0555, 8'hA0, 8'h02, 4'h0);
    wr(16'h1234, 8'h3C, 8'h02, 4'h0);
    chk("R8 prog pulse", mon_mask, 5'b00001);
    chk("R8 addr", mon_addr, 16'h1234);
    chk("R8 data", mon_data, 8'h3C);
    chk("R8 arr", mon_arr, 0);
    chk("R3 sector lowest", mon_sec, 4'd1);
    chk("R14 one cycle", mon_cyc, 1);

    // R9 chip erase
    clr();
    unl(8'h01, 4'h0); wr(16'h0555, 8'h80, 8'h01, 4'h0);
    unl(8'h01, 4'h0); wr(16'h0555, 8'h10, 8'h01, 4'h0);
    chk("R9 chip erase", mon_mask, 5'b00010);
    // R9 sector erase on secondary
    clr();
    unl(8'h00, 4'h4); wr(16'h0555, 8'h80, 8'h00, 4'h4);
    unl(8'h00, 4'h4); wr(16'h2000, 8'h30, 8'h00, 4'h6);
    chk("R9 sector erase", mon_mask, 5'b00100);
    chk("R9 sector arr", mon_arr, 1);
    chk("R3 boot sector index", mon_sec, 4'd9);

    // R4 bad address / data
    wr(16'h0555, 8'hAA, 8'h01, 4'h0);
    wr(16'h0555, 8'h55, 8'h01, 4'h0);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R4 bad address", v, 8'h5B);
    wr(16'h0555, 8'hAA, 8'h01, 4'h0);
    wr(16'h0AAA, 8'h54, 8'h01, 4'h0);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R4 bad data", v, 8'h5B);
    clr();
    unl(8'h01, 4'h0); wr(16'h0555, 8'h80, 8'h01, 4'h0);
    unl(8'h01, 4'h0); wr(16'h0555, 8'h11, 8'h01, 4'h0);
    chk("R4 bad erase confirm", mon_mask, 0);
    // R4 array change mid sequence
    clr();
    unl(8'h01, 4'h0);
    wr(16'h0555, 8'hA0, 8'h00, 4'h1);
    wr(16'h0010, 8'h99, 8'h00, 4'h1);
    chk("R4 array mismatch", mon_mask, 0);

    // R3 unselected write ignored, primary priority
    wr(16'h0555, 8'hAA, 8'h01, 4'h0);
    wr(16'h0AAA, 8'h55, 8'h00, 4'h0);
    wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R3 unselected ignored", v, IDC);
    wr(16'h0000, 8'hF0, 8'h01, 4'h0);
    clr();
    unl(8'h80, 4'h1);
    wr(16'h0555, 8'hA0, 8'h80, 4'h1);
    wr(16'h0055, 8'h66, 8'h80, 4'h0);
    chk("R3 both groups primary", mon_arr, 0);
    chk("R3 both groups sector", mon_sec, 4'd7);

    // R6 lockout
    unl(8'h01, 4'h0);
    lockout = 1'b1;
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    lockout = 1'b0;
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R6 locked write ignored", v, IDC);
    wr(16'h0000, 8'hF0, 8'h01, 4'h0);
    clr();
    unl(8'h01, 4'h0); wr(16'h0555, 8'hA0, 8'h01, 4'h0);
    lockout = 1'b1;
    wr(16'h0100, 8'h11, 8'h01, 4'h0);
    lockout = 1'b0;
    chk("R6 no prog under lockout", mon_mask, 0);
    wr(16'h0101, 8'h22, 8'h01, 4'h0);
    chk("R6 prog after lockout", mon_data, 8'h22);

    // R5 timeout
    wr(16'h0555, 8'hAA, 8'h01, 4'h0);
    wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
    repeat (80) @(negedge clk);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R5 long gap aborts", v, 8'h5B);
    wr(16'h0555, 8'hAA, 8'h01, 4'h0);
    repeat (40) @(negedge clk);
    wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
    repeat (40) @(negedge clk);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R5 short gap kept", v, IDC);
    wr(16'h0000, 8'hF0, 8'h01, 4'h0);

    // R12 bypass mode
    clr();
    unl(8'h01, 4'h0); wr(16'h0555, 8'h20, 8'h01, 4'h0);
    wr(16'h0300, 8'hA0, 8'h01, 4'h0);
    wr(16'h0301, 8'h5E, 8'h01, 4'h0);
    chk("R12 bypass prog", mon_mask, 5'b00001);
    chk("R12 bypass prog data", mon_data, 8'h5E);
    chk("R12 bypass prog addr", mon_addr, 16'h0301);
    wr(16'h0000, 8'h44, 8'h01, 4'h0);
    chk("R12 bad byte stays", bypass, 1);
    wr(16'h0000, 8'h90, 8'h01, 4'h0);
    wr(16'h0000, 8'h55, 8'h01, 4'h0);
    chk("R12 bad exit stays", bypass, 1);
    clr();
    wr(16'h0000, 8'hA0, 8'h01, 4'h0);
    repeat (80) @(negedge clk);
    wr(16'h0077, 8'h12, 8'h01, 4'h0);
    chk("R12 R5 bypass timeout no prog", mon_mask, 0);
    chk("R12 still bypass", bypass, 1);
    wr(16'h0000, 8'h90, 8'h01, 4'h0);
    wr(16'h0000, 8'h00, 8'h01, 4'h0);
    chk("R12 exit", bypass, 0);

    // R13 busy
    busy = 1'b1;
    rd(16'h0001, 8'h01, 4'h0, v);
    chk("R13 status data", v, 8'hC3);
    chk("R13 status flag", status_rd, 1);
    busy = 1'b0;
    rd(16'h0001, 8'h01, 4'h0, v);
    chk("R13 busy off", v, 8'h5B);

    // R7 strobe low at reset release
    @(negedge clk);
    rst_n = 1'b0;
    addr = 16'h0555; data = 8'hAA; psel = 8'h01; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    psel = '0;
    wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
    wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R7 first edge ignored", v, 8'h5B);
    unl(8'h01, 4'h0); wr(16'h0555, 8'h90, 8'h01, 4'h0);
    rd(16'h0001, 8'h01, 4'h0, v); chk("R7 armed afterwards", v, IDC);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule